// File: doc/BRIEF.md
# Overlapping Segment Capture Controller

This block takes the complex baseband samples of one chirp and splits them into fixed windows of 2048 samples for a downstream processing chain. Neighbouring windows share 128 samples, so each window after the first starts 1920 samples after the one before it. The chirp length comes from a mode input. A short or medium chirp fits in one window. A long chirp of 3000 samples needs two.

Capture is separate from sequencing. From the cycle after an accepted start pulse, every valid input sample goes into a 4096-entry store at the address equal to its arrival index. This continues whatever the sequencer is doing. Samples that arrive while window 0 is still being processed are therefore kept. The sequencer waits until the store holds every in-range sample of the current window. It then raises a request and, once the chain grants it, streams the window out at one sample per cycle. Window positions past the chirp end are sent as zero. The sequencer then waits for the chain's completion pulse before it moves to the next window or finishes.

State codes and transitions:
- IDLE (0) moves to COLLECT on start.
- COLLECT (1) moves to REQUEST once capture covers the window.
- REQUEST (2) moves to STREAM on ready.
- STREAM (3) moves to WAIT after the 2048th read.
- WAIT (4) moves to OUTPUT on proc_done.
- OUTPUT (6) moves to IDLE on the final window, otherwise to NEXT.
- NEXT (7) moves to OVERLAP.
- OVERLAP (8) moves to COLLECT.

Top module: `segcap_ctrl`

## Requirements
- R1: A synchronous active-high reset forces status to 0 (idle) and clears seg_index, seg_req, out_valid and done.
- R2: After an accepted start, the n-th sample presented with in_valid high goes to store address n, whatever the sequencing state. Samples presented while idle, and cycles with in_valid low, are not counted.
- R3: Window k streams 2048 consecutive out_valid beats. Beat p carries the sample at store address k*1920+p, so window k+1 begins with the last 128 samples of window k.
- R4: A beat whose address k*1920+p is at or beyond the chirp length carries zero on both out_i and out_q.
- R5: Mode code 0 selects 100 samples and one window. Code 1 selects 500 samples and one window. Codes 2 and 3 select 3000 samples and two windows. No further request follows the last window.
- R6: seg_req for window k rises only when the captured count is at least min(k*1920+2048, chirp length). Streaming begins only after seg_ready is seen high while seg_req is high.
- R7: The status output shows the state codes IDLE 0, COLLECT 1, REQUEST 2, STREAM 3, WAIT 4, OUTPUT 6, NEXT 7 and OVERLAP 8. It moves only along the transitions listed above. OUTPUT lasts one cycle.
- R8: WAIT holds until proc_done is high. A proc_done pulse in any other state has no effect.
- R9: seg_index is 0 for the first window and rises by one on the move from OVERLAP to COLLECT.
- R10: The cycle after OUTPUT of the final window, done is high for one cycle, status is 0 and seg_index is 0. A new start pulse is then accepted.
- R11: A start pulse, or a change of mode, while a chirp is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Chirp start pulse, accepted only in IDLE |
| mode | input | 2 | Chirp length select, latched at start |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DATA_W | Input in-phase sample |
| in_q | input | DATA_W | Input quadrature sample |
| seg_req | output | 1 | Window ready to send |
| seg_ready | input | 1 | Chain accepts the requested window |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DATA_W | Output in-phase sample |
| out_q | output | DATA_W | Output quadrature sample |
| proc_done | input | 1 | Chain finished the current window |
| status | output | 4 | Sequencer state code |
| seg_index | output | IDX_W | Current window index |
| done | output | 1 | One-cycle pulse after the final window |

## Verification
The assertions assume the following about the inputs:
- The chain pulses seg_ready only in response to a request.
- The chirp lengths set by the parameters fit in the store.
- A step of the capture count away from its previous value is either an increment or a clear at start or at finish.

The stimulus drives the handshake inputs and the start pulse for single cycles away from the clock edge. It waits for the done pulse before the next start. Stray pulses are placed on purpose: a proc_done in the middle of a stream, and a start plus a mode change during collection. These test the ignore rules without breaking what the properties assume.

// File: rtl/segcap_pkg.sv
package segcap_pkg;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_COLLECT = 4'd1,
        S_REQUEST = 4'd2,
        S_STREAM  = 4'd3,
        S_WAIT    = 4'd4,
        S_OUTPUT  = 4'd6,
        S_NEXT    = 4'd7,
        S_OVERLAP = 4'd8
    } seq_state_t;

endpackage

// File: rtl/segcap_sample_store.sv
module segcap_sample_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4096,
    parameter int CNT_W  = 13,
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                enable,
    input  logic [CNT_W-1:0]    limit,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_i,
    input  logic [DATA_W-1:0]   in_q,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [CNT_W-1:0]    count,
    output logic [2*DATA_W-1:0] rd_word
);

    localparam int WORD_W = 2 * DATA_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic              take;

    // a sample is taken when capture is live and the chirp is not yet full
    assign take = enable && in_valid && (count < limit) && !clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (take) begin
            count <= count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            mem[count[ADDR_W-1:0]] <= {in_i, in_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_word <= mem[rd_addr];
        end
    end

    AST_CAPTURE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        enable |-> (count <= limit)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + CNT_W'(1) || count == '0)); // R2

endmodule

// File: rtl/segcap_window_reader.sv
module segcap_window_reader #(
    parameter int CNT_W   = 13,
    parameter int ADDR_W  = 12,
    parameter int SEG_LEN = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [CNT_W-1:0]  seg_base,
    input  logic [CNT_W-1:0]  chirp_len,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              last_beat,
    output logic              out_valid,
    output logic              out_zero
);

    localparam int POS_W = $clog2(SEG_LEN);

    logic [POS_W-1:0] pos;
    logic [CNT_W:0]   abs_pos;
    logic             in_range;
    logic             unused_hi;

    assign abs_pos   = {1'b0, seg_base} + (CNT_W+1)'(pos);
    assign in_range  = abs_pos < {1'b0, chirp_len};
    assign rd_en     = go;
    assign rd_addr   = abs_pos[ADDR_W-1:0];
    assign last_beat = go && (pos == POS_W'(SEG_LEN - 1));
    assign unused_hi = &{1'b0, abs_pos[CNT_W:ADDR_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (go) begin
            pos <= last_beat ? '0 : pos + POS_W'(1);
        end else begin
            pos <= '0;
        end
    end

    // read data arrives one cycle after the address, flags follow it
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_zero  <= 1'b0;
        end else begin
            out_valid <= go;
            out_zero  <= !in_range;
        end
    end

endmodule

// File: rtl/segcap_sequencer.sv
module segcap_sequencer
    import segcap_pkg::*;
#(
    parameter int CNT_W      = 13,
    parameter int IDX_W      = 2,
    parameter int SEG_LEN    = 2048,
    parameter int STEP       = 1920,
    parameter int SHORT_LEN  = 100,
    parameter int MEDIUM_LEN = 500,
    parameter int LONG_LEN   = 3000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic             seg_ready,
    input  logic             proc_done,
    input  logic             last_beat,
    input  logic [CNT_W-1:0] cap_count,
    output seq_state_t       state,
    output logic [IDX_W-1:0] seg_idx,
    output logic [CNT_W-1:0] seg_base,
    output logic [CNT_W-1:0] chirp_len,
    output logic             capture_clear,
    output logic             capture_en,
    output logic             seg_req,
    output logic             done
);

    localparam logic [CNT_W-1:0] LEN_S = CNT_W'(SHORT_LEN);
    localparam logic [CNT_W-1:0] LEN_M = CNT_W'(MEDIUM_LEN);
    localparam logic [CNT_W-1:0] LEN_L = CNT_W'(LONG_LEN);

    seq_state_t       nxt;
    logic [CNT_W-1:0] len_sel;
    logic [CNT_W:0]   seg_end;
    logic             window_full;
    logic             is_last;

    always_comb begin
        case (mode)
            2'd0:    len_sel = LEN_S;
            2'd1:    len_sel = LEN_M;
            default: len_sel = LEN_L;
        endcase
    end

    assign seg_end     = {1'b0, seg_base} + (CNT_W+1)'(SEG_LEN);
    assign window_full = ({1'b0, cap_count} >= seg_end) || (cap_count >= chirp_len);
    assign is_last     = seg_end >= {1'b0, chirp_len};

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start)       nxt = S_COLLECT;
            S_COLLECT: if (window_full) nxt = S_REQUEST;
            S_REQUEST: if (seg_ready)   nxt = S_STREAM;
            S_STREAM:  if (last_beat)   nxt = S_WAIT;
            S_WAIT:    if (proc_done)   nxt = S_OUTPUT;
            S_OUTPUT:  nxt = is_last ? S_IDLE : S_NEXT;
            S_NEXT:    nxt = S_OVERLAP;
            S_OVERLAP: nxt = S_COLLECT;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_idx   <= '0;
            seg_base  <= '0;
            chirp_len <= '0;
            done      <= 1'b0;
        end else begin
            done <= (state == S_OUTPUT) && is_last;
            if (state == S_IDLE && start) begin
                chirp_len <= len_sel;
                seg_idx   <= '0;
                seg_base  <= '0;
            end else if (state == S_OVERLAP) begin
                seg_idx   <= seg_idx + IDX_W'(1);
                seg_base  <= seg_base + CNT_W'(STEP);
            end else if (state == S_OUTPUT && is_last) begin
                seg_idx   <= '0;
                seg_base  <= '0;
            end
        end
    end

    assign capture_clear = (state == S_IDLE && start) || (state == S_OUTPUT && is_last);
    assign capture_en    = (state != S_IDLE);
    assign seg_req       = (state == S_REQUEST);

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && !proc_done) |=> (state == S_WAIT)); // R8

    AST_INDEX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (state == S_COLLECT && $past(state) == S_OVERLAP) |-> (seg_idx == $past(seg_idx) + IDX_W'(1))); // R9

    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == S_IDLE && seg_idx == '0 && seg_base == '0)); // R10

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(chirp_len)); // R11

endmodule

// File: rtl/segcap_ctrl.sv
module segcap_ctrl
    import segcap_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 4096,
    parameter int SEG_LEN    = 2048,
    parameter int OVERLAP    = 128,
    parameter int SHORT_LEN  = 100,
    parameter int MEDIUM_LEN = 500,
    parameter int LONG_LEN   = 3000,
    localparam int STEP      = SEG_LEN - OVERLAP,
    localparam int MAX_SEGS  = (DEPTH - SEG_LEN + STEP - 1) / STEP + 1,
    localparam int IDX_W     = $clog2(MAX_SEGS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    output logic              seg_req,
    input  logic              seg_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q,
    input  logic              proc_done,
    output logic [3:0]        status,
    output logic [IDX_W-1:0]  seg_index,
    output logic              done
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    seq_state_t           state;
    logic [CNT_W-1:0]     seg_base;
    logic [CNT_W-1:0]     chirp_len;
    logic [CNT_W-1:0]     cap_count;
    logic                 capture_clear;
    logic                 capture_en;
    logic                 last_beat;
    logic                 rd_en;
    logic [ADDR_W-1:0]    rd_addr;
    logic [2*DATA_W-1:0]  rd_word;
    logic                 out_zero;

    segcap_sequencer #(
        .CNT_W(CNT_W), .IDX_W(IDX_W), .SEG_LEN(SEG_LEN), .STEP(STEP),
        .SHORT_LEN(SHORT_LEN), .MEDIUM_LEN(MEDIUM_LEN), .LONG_LEN(LONG_LEN)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .seg_ready(seg_ready), .proc_done(proc_done), .last_beat(last_beat),
        .cap_count(cap_count), .state(state), .seg_idx(seg_index),
        .seg_base(seg_base), .chirp_len(chirp_len),
        .capture_clear(capture_clear), .capture_en(capture_en),
        .seg_req(seg_req), .done(done)
    );

    segcap_sample_store #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_store (
        .clk(clk), .rst(rst), .clear(capture_clear), .enable(capture_en),
        .limit(chirp_len), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .rd_en(rd_en), .rd_addr(rd_addr), .count(cap_count), .rd_word(rd_word)
    );

    segcap_window_reader #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SEG_LEN(SEG_LEN)
    ) u_reader (
        .clk(clk), .rst(rst), .go(state == S_STREAM), .seg_base(seg_base),
        .chirp_len(chirp_len), .rd_en(rd_en), .rd_addr(rd_addr),
        .last_beat(last_beat), .out_valid(out_valid), .out_zero(out_zero)
    );

    assign out_i  = (out_valid && !out_zero) ? rd_word[2*DATA_W-1:DATA_W] : '0;
    assign out_q  = (out_valid && !out_zero) ? rd_word[DATA_W-1:0]        : '0;
    assign status = state;

    AST_REQ_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        seg_req |-> (({1'b0, cap_count} >= {1'b0, seg_base} + (CNT_W+1)'(SEG_LEN))
                     || (cap_count >= chirp_len))); // R6

    AST_OUT_IN_STREAM: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (state == S_STREAM || state == S_WAIT)); // R3

endmodule

// File: tb/segcap_ctrl_test.sv
module segcap_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int SEG        = 2048;
    localparam int STEP       = 1920;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] gap;
        logic [15:0] lat;
        logic [15:0] rdy;
        logic        busy;
        logic [1:0]  nseg;
        logic [15:0] len;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 16'd0, 16'd10,   16'd0, 1'b0, 2'd1, 16'd100},
        '{2'd1, 16'd2, 16'd20,   16'd3, 1'b1, 2'd1, 16'd500},
        '{2'd2, 16'd0, 16'd6000, 16'd0, 1'b0, 2'd2, 16'd3000},
        '{2'd2, 16'd3, 16'd10,   16'd5, 1'b1, 2'd2, 16'd3000},
        '{2'd3, 16'd1, 16'd100,  16'd1, 1'b0, 2'd2, 16'd3000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        seg_req;
    logic        seg_ready = 1'b0;
    logic        out_valid;
    logic [15:0] out_i;
    logic [15:0] out_q;
    logic        proc_done = 1'b0;
    logic [3:0]  status;
    logic [1:0]  seg_index;
    logic        done;

    int checks = 0;
    int errors = 0;
    int fed = 0;
    int illegal = 0;
    logic [3:0] prev_status = 4'd0;

    segcap_ctrl uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .seg_req(seg_req), .seg_ready(seg_ready),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
        .proc_done(proc_done), .status(status), .seg_index(seg_index), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] smp_i(int n, int v);
        return 16'(n * 7 + v * 1000 + 1);
    endfunction

    function automatic logic [15:0] smp_q(int n, int v);
        return 16'(40000 - n * 3 + v);
    endfunction

    function automatic int need_of(int k, int len);
        return (k * STEP + SEG < len) ? k * STEP + SEG : len;
    endfunction

    function automatic bit legal_step(logic [3:0] a, logic [3:0] b);
        case ({a, b})
            {4'd0, 4'd1}, {4'd1, 4'd2}, {4'd2, 4'd3}, {4'd3, 4'd4}, {4'd4, 4'd6},
            {4'd6, 4'd7}, {4'd6, 4'd0}, {4'd7, 4'd8}, {4'd8, 4'd1}: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // status transition monitor for R7
    always @(negedge clk) begin
        if (!rst && status != prev_status && !legal_step(prev_status, status)) begin
            illegal++;
        end
        prev_status <= status;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic run_vec(input int v);
        vec_t vc = VECS[v];
        int len = int'(vc.len);
        int bad_data = 0;
        int bad_zero = 0;
        fed = 0;
        illegal = 0;
        // samples presented in idle must be ignored (R2)
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            in_valid = 1'b1; in_i = 16'hDEAD; in_q = 16'hDEAD;
        end
        @(negedge clk);
        in_valid = 1'b0;
        mode = vc.mode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            begin : feeder
                for (int n = 0; n < len + 4; n++) begin
                    in_valid = 1'b1;
                    in_i = (n < len) ? smp_i(n, v) : 16'hBEEF;
                    in_q = (n < len) ? smp_q(n, v) : 16'hBEEF;
                    @(posedge clk);
                    fed = n + 1;
                    @(negedge clk);
                    in_valid = 1'b0;
                    repeat (int'(vc.gap)) @(negedge clk);
                end
            end
            begin : stray_start
                if (vc.busy) begin
                    repeat (40) @(negedge clk);
                    start = 1'b1;
                    mode = 2'd0;
                    @(negedge clk);
                    start = 1'b0;
                    mode = vc.mode;
                end
            end
            begin : chain
                for (int k = 0; k < int'(vc.nseg); k++) begin
                    while (!seg_req) @(negedge clk);
                    chk(fed >= need_of(k, len), "R6", "samples held at request",
                        fed, need_of(k, len));
                    repeat (int'(vc.rdy)) @(negedge clk);
                    chk(status == 4'd2 && !out_valid, "R6", "held before ready",
                        status, 2);
                    seg_ready = 1'b1;
                    @(negedge clk);
                    seg_ready = 1'b0;
                    for (int p = 0; p < SEG; p++) begin
                        int a = k * STEP + p;
                        logic [15:0] ei = (a < len) ? smp_i(a, v) : 16'd0;
                        logic [15:0] eq = (a < len) ? smp_q(a, v) : 16'd0;
                        @(negedge clk);
                        if (p == 0) begin
                            while (!out_valid) @(negedge clk);
                            chk(seg_index == 2'(k), "R9", "index during stream", seg_index, k);
                        end
                        proc_done = (p == 1000);
                        if (!out_valid || out_i != ei || out_q != eq) begin
                            if (a < len) begin
                                if (bad_data == 0)
                                    $display("FAIL R3 seg %0d pos %0d: actual %h/%h/%0d expected %h/%h/1",
                                             k, p, out_i, out_q, out_valid, ei, eq);
                                bad_data++;
                            end else begin
                                if (bad_zero == 0)
                                    $display("FAIL R4 seg %0d pos %0d: actual %h/%h/%0d expected 0/0/1",
                                             k, p, out_i, out_q, out_valid);
                                bad_zero++;
                            end
                        end
                    end
                    proc_done = 1'b0;
                    chk(bad_data == 0, "R3", "window data mismatches", bad_data, 0);
                    chk(bad_zero == 0, "R4", "zero fill mismatches", bad_zero, 0);
                    repeat (int'(vc.lat)) @(negedge clk);
                    chk(status == 4'd4, "R8", "wait held until done pulse", status, 4);
                    proc_done = 1'b1;
                    @(negedge clk);
                    proc_done = 1'b0;
                    chk(status == 4'd6, "R7", "output state", status, 6);
                    @(negedge clk);
                    if (k == int'(vc.nseg) - 1) begin
                        chk(done && status == 4'd0 && seg_index == 2'd0, "R10",
                            "done pulse and idle", {done, status, seg_index}, 7'b1_0000_00);
                    end else begin
                        chk(status == 4'd7, "R7", "next-segment state", status, 7);
                    end
                end
            end
        join
        repeat (20) @(negedge clk);
        chk(status == 4'd0 && !seg_req && !done, "R5", "no extra window after last",
            {seg_req, status}, 0);
        chk(illegal == 0, "R7", "illegal status transitions", illegal, 0);
        if (vc.busy) begin
            chk(bad_data == 0 && bad_zero == 0, "R11", "stray start ignored",
                bad_data + bad_zero, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(status == 4'd0 && seg_index == 2'd0 && !seg_req && !out_valid && !done,
            "R1", "reset state", {status, seg_index, seg_req, out_valid, done}, 0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            run_vec(v);
        end

        // reset in the middle of a long chirp (R1)
        @(negedge clk);
        mode = 2'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 500; n++) begin
            in_valid = 1'b1;
            in_i = smp_i(n, 9);
            in_q = smp_q(n, 9);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(status == 4'd0 && seg_index == 2'd0 && !seg_req && !out_valid && !done,
            "R1", "reset mid chirp", {status, seg_index, seg_req, out_valid, done}, 0);

        // a fresh chirp after reset is accepted (R10)
        run_vec(0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule